// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master side of a single-wire, open-drain bus. Software reaches it through a small 16-bit register file. It runs three kinds of bus action. The first is a reset pulse with a presence check. The second is a slot that drives a 0. The third is a slot that releases the line, so it writes a 1 and reads back whatever a device pulls it to. A programmable divider derives a microsecond tick from the system clock, and every bus time is counted in that tick.

Software has two ways to drive the bus. It can start single-bit actions through self-clearing bits in the control register. It can also write a byte to the data register. The byte is then shifted out least-significant bit first, one slot per bit, on the same slot engine. The bus level sampled in each slot is shifted into a receive byte, so a read is a write of 0xFF. Status flags report the state of the holding buffer, the shift register and the receive buffer. A one-byte holding buffer lets a second byte be queued while the first is still on the wire.

The line is modelled as an active-high pull-low enable plus a separate input. That input passes through a two-flop synchronizer before it is used.

Top module: `ow_master`

## Requirements
- R1: Register offsets are: control 0, divider 1, data 2, status 3, interrupt enable 4. After reset, control reads 0x0000, status reads 0x000C (holding buffer empty, shift register empty), divider reads the DIV_INIT parameter (default 99) and data reads 0x0000.
- R2: The divider register holds N-1, and one tick occurs every N system clocks. A pull-low phase of L ticks therefore lasts between (L-1)*N+1 and L*N clocks, for every value written.
- R3: Writing control bit 7 starts a reset sequence. The line is pulled low for 480 ticks and then released for 410 ticks. Bit 7 reads 1 while the sequence runs and clears itself at the end.
- R4: Control bit 6 is updated at the end of each reset sequence. It reads 1 if the line was low 70 ticks after release, meaning a device answered, and 0 otherwise.
- R5: Writing control bit 5 runs a drive-0 slot with 60 ticks low. Writing bit 4 runs a write-1/read slot with 6 ticks low. Each slot lasts 70 ticks, so at least 10 released ticks separate consecutive slots. Each start bit reads 1 while its slot runs and then clears itself.
- R6: Control bit 3 holds the line level sampled 15 ticks into the most recent write-1/read slot started from the control register.
- R7: A control write is ignored while a bus action is running, while a byte is in flight, or while a byte is waiting in the holding buffer.
- R8: A data write sends the low 8 bits least-significant first. A 1 bit becomes a write-1/read slot and a 0 bit becomes a drive-0 slot.
- R9: The line level sampled in each byte slot is shifted in least-significant first. At the end of the byte, status bit 3 (shift register empty), bit 4 (receive buffer full) and bit 5 (receive shift complete) are set, and data reads the received byte.
- R10: A read of the data register returns the received byte and clears status bit 4.
- R11: Status bit 2 reads 1 while the holding buffer is empty. A data write fills the buffer. The byte moves to the shift register as soon as the shift register and the slot engine are idle. A data write made while bit 2 is 0 is ignored.
- R12: The interrupt-enable register stores bits 5 to 2 of a write and reads all other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ow_drive_low | output | 1 | Pull the bus line low when 1 |
| ow_bus_in | input | 1 | Bus line level, asynchronous |

## Verification
The assertions assume that software does not rewrite the divider while the line is being pulled low. The bound on pull-low duration is scaled by the divider value that is current at the time. The bench therefore changes the divider only after polling the control and status registers until every action and byte has finished. The assertions also assume that the bus input may change at any time relative to the clock. The bench's device model changes the line only on the falling half of the clock, at the start of each slot, and holds it steady until the next slot.

// File: rtl/ow_pkg.sv
package ow_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    // Bus timing in microsecond ticks
    localparam int RST_LOW_T = 480;
    localparam int RST_REL_T = 410;
    localparam int PRES_T    = 70;
    localparam int SLOT_T    = 70;
    localparam int W0_LOW_T  = 60;
    localparam int W1_LOW_T  = 6;
    localparam int SAMP_T    = 15;
    localparam int CNT_W     = $clog2(RST_LOW_T + RST_REL_T + 1);

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;

    localparam int C_RST  = 7;
    localparam int C_PRES = 6;
    localparam int C_W0   = 5;
    localparam int C_W1   = 4;
    localparam int C_RDB  = 3;

    typedef enum logic [1:0] {
        SLOT_RESET = 2'd0,
        SLOT_W0    = 2'd1,
        SLOT_W1R   = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic rsrf;
        logic rbf;
        logic tsre;
        logic tbe;
    } byte_flags_t;

    function automatic logic [CNT_W-1:0] low_ticks(input slot_kind_e k);
        case (k)
            SLOT_RESET: low_ticks = CNT_W'(RST_LOW_T);
            SLOT_W0:    low_ticks = CNT_W'(W0_LOW_T);
            default:    low_ticks = CNT_W'(W1_LOW_T);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] last_tick(input slot_kind_e k);
        if (k == SLOT_RESET) last_tick = CNT_W'(RST_LOW_T + RST_REL_T - 1);
        else                 last_tick = CNT_W'(SLOT_T - 1);
    endfunction

    function automatic logic [CNT_W-1:0] samp_tick(input slot_kind_e k);
        if (k == SLOT_RESET) samp_tick = CNT_W'(RST_LOW_T + PRES_T);
        else                 samp_tick = CNT_W'(SAMP_T);
    endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen
    import ow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] div,
    output logic             tick
);
    logic [REG_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import ow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  slot_kind_e start_kind,
    input  logic       bus_s,
    output logic       busy,
    output logic       done,
    output slot_kind_e kind,
    output logic       drive_low,
    output logic       sample
);
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             busy_n;
    slot_kind_e       kind_n;

    always_comb begin
        busy_n = busy;
        cnt_n  = cnt;
        kind_n = kind;
        done   = 1'b0;
        if (!busy) begin
            if (start) begin
                busy_n = 1'b1;
                cnt_n  = '0;
                kind_n = start_kind;
            end
        end else if (tick) begin
            if (cnt == last_tick(kind)) begin
                done   = 1'b1;
                busy_n = 1'b0;
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            kind      <= SLOT_W1R;
            drive_low <= 1'b0;
            sample    <= 1'b0;
        end else begin
            busy      <= busy_n;
            cnt       <= cnt_n;
            kind      <= kind_n;
            drive_low <= busy_n && (cnt_n < low_ticks(kind_n));
            if (busy && tick && cnt == samp_tick(kind))
                sample <= bus_s;
        end
    end
endmodule

// File: rtl/ow_byte_unit.sv
module ow_byte_unit
    import ow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_ack,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_sample,
    output logic              slot_start,
    output slot_kind_e        slot_kind,
    output byte_flags_t       flags,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] hold, tx_sh, rx_sh, rx_next;
    logic [IDX_W-1:0]  idx;
    logic              active, load;

    assign load       = !flags.tbe && !active && !eng_busy;
    assign slot_start = active && !eng_busy;
    assign slot_kind  = tx_sh[0] ? SLOT_W1R : SLOT_W0;
    assign flags.tsre = !active;
    assign rx_next    = {eng_sample, rx_sh[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold       <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            rx_byte    <= '0;
            idx        <= '0;
            active     <= 1'b0;
            flags.tbe  <= 1'b1;
            flags.rbf  <= 1'b0;
            flags.rsrf <= 1'b0;
        end else begin
            if (wr_req && flags.tbe) begin
                hold      <= wr_byte;
                flags.tbe <= 1'b0;
            end
            if (load) begin
                tx_sh      <= hold;
                flags.tbe  <= 1'b1;
                active     <= 1'b1;
                idx        <= '0;
                flags.rsrf <= 1'b0;
            end
            if (rd_ack) flags.rbf <= 1'b0;
            if (active && eng_done) begin
                rx_sh <= rx_next;
                tx_sh <= tx_sh >> 1;
                idx   <= idx + 1'b1;
                if (idx == IDX_W'(BYTE_W - 1)) begin
                    active     <= 1'b0;
                    rx_byte    <= rx_next;
                    flags.rbf  <= 1'b1;
                    flags.rsrf <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter logic [15:0] DIV_INIT = 16'd99
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ow_drive_low,
    input  logic              ow_bus_in
);
    logic              bus_s1, bus_s2, tick;
    logic [REG_W-1:0]  div_q;
    logic [3:0]        ien_q;
    logic              presence_q, rdbit_q;
    logic              eng_busy, eng_done, eng_sample, eng_start;
    slot_kind_e        eng_kind, start_kind, ctrl_kind, byte_kind;
    logic              ctrl_wr, ctrl_go, byte_start;
    logic              st_tbe, st_tsre, st_rbf;
    byte_flags_t       flags;
    logic [BYTE_W-1:0] rx_byte;

    assign st_tbe  = flags.tbe;
    assign st_tsre = flags.tsre;
    assign st_rbf  = flags.rbf;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_s1 <= 1'b1;
            bus_s2 <= 1'b1;
        end else begin
            bus_s1 <= ow_bus_in;
            bus_s2 <= bus_s1;
        end
    end

    // Control-register start decode; reset has priority over drive-0 over write-1
    assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
    always_comb begin
        ctrl_kind = SLOT_W1R;
        if (reg_wdata[C_RST])     ctrl_kind = SLOT_RESET;
        else if (reg_wdata[C_W0]) ctrl_kind = SLOT_W0;
        ctrl_go = ctrl_wr && !eng_busy && st_tsre && st_tbe &&
                  (reg_wdata[C_RST] || reg_wdata[C_W0] || reg_wdata[C_W1]);
    end

    assign eng_start  = ctrl_go || byte_start;
    assign start_kind = ctrl_go ? ctrl_kind : byte_kind;

    ow_tick_gen i_tick (
        .clk(clk), .rst(rst), .div(div_q), .tick(tick)
    );

    ow_slot_engine i_eng (
        .clk(clk), .rst(rst), .tick(tick), .start(eng_start),
        .start_kind(start_kind), .bus_s(bus_s2), .busy(eng_busy),
        .done(eng_done), .kind(eng_kind), .drive_low(ow_drive_low),
        .sample(eng_sample)
    );

    ow_byte_unit i_byte (
        .clk(clk), .rst(rst),
        .wr_req(reg_wr && reg_addr == A_DATA),
        .wr_byte(reg_wdata[BYTE_W-1:0]),
        .rd_ack(reg_rd && reg_addr == A_DATA),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_sample(eng_sample),
        .slot_start(byte_start), .slot_kind(byte_kind),
        .flags(flags), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= DIV_INIT;
            ien_q      <= '0;
            presence_q <= 1'b0;
            rdbit_q    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata;
            if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[5:2];
            if (eng_done && st_tsre) begin
                if (eng_kind == SLOT_RESET) presence_q <= !eng_sample;
                if (eng_kind == SLOT_W1R)   rdbit_q    <= eng_sample;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_RST]  = eng_busy && st_tsre && eng_kind == SLOT_RESET;
                reg_rdata[C_PRES] = presence_q;
                reg_rdata[C_W0]   = eng_busy && st_tsre && eng_kind == SLOT_W0;
                reg_rdata[C_W1]   = eng_busy && st_tsre && eng_kind == SLOT_W1R;
                reg_rdata[C_RDB]  = rdbit_q;
            end
            A_DIV:  reg_rdata = div_q;
            A_DATA: reg_rdata[BYTE_W-1:0] = rx_byte;
            A_STAT: reg_rdata[5:2] = flags;
            A_IEN:  reg_rdata[5:2] = ien_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk
    import ow_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ow_drive_low,
    input logic             eng_busy,
    input logic             eng_done,
    input slot_kind_e       eng_kind,
    input logic             st_tbe,
    input logic             st_tsre,
    input logic             st_rbf,
    input logic [REG_W-1:0] div_q
);
    logic [31:0] low_run;
    logic [31:0] low_max;

    assign low_max = RST_LOW_T * (32'(div_q) + 32'd1);

    always_ff @(posedge clk) begin
        if (rst)               low_run <= '0;
        else if (ow_drive_low) low_run <= low_run + 1'b1;
        else                   low_run <= '0;
    end

    p_drive_in_action_r5: assert property (@(posedge clk) disable iff (rst)
        ow_drive_low |-> eng_busy);

    p_low_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        low_run <= low_max);

    p_kind_held_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !eng_done) |=> $stable(eng_kind));

    p_rbf_from_slot_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_rbf) |-> $past(eng_done));

    p_load_from_hold_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(st_tsre) |-> $past(!st_tbe));
endmodule

bind ow_master ow_master_chk i_chk (
    .clk(clk), .rst(rst), .ow_drive_low(ow_drive_low), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_kind(eng_kind), .st_tbe(st_tbe),
    .st_tsre(st_tsre), .st_rbf(st_rbf), .div_q(div_q)
);

// File: tb/test_ow_master.sv
module test_ow_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ow_drive_low;
    logic        ow_bus_in;

    always #4 clk = ~clk;

    // Device model: 0 none, 1 hold line low, 2 per-slot pattern
    int          smode = 0;
    logic [7:0]  pat = '0;
    logic [2:0]  pidx = '0;
    logic        pat_pull = 1'b0;
    logic        prev_drv = 1'b0;
    logic        pull;
    assign pull      = (smode == 1) || (smode == 2 && pat_pull);
    assign ow_bus_in = !(ow_drive_low || pull);

    // Line monitor
    int         cur_div = 99;
    int         run = 0, hi_run = 0, last_len = 0, slot_cnt = 0, min_gap = 0;
    logic [7:0] obs = '0;

    always @(negedge clk) begin
        if (ow_drive_low && !prev_drv) begin
            if (smode == 2) pat_pull = !pat[pidx];
            pidx = pidx + 1'b1;
            if (hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
        prev_drv = ow_drive_low;
        if (ow_drive_low) run++;
        else begin
            hi_run++;
            if (run != 0) begin
                last_len = run;
                slot_cnt++;
                obs = {(run < 30 * (cur_div + 1)), obs[7:1]};
                run = 0;
            end
        end
    end

    ow_master i_ow_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ow_drive_low(ow_drive_low), .ow_bus_in(ow_bus_in)
    );

    int errors = 0, checks = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] c, s;
        do begin
            rd(3'd0, c);
            rd(3'd3, s);
        end while ((c & 16'h00B0) != 0 || (s & 16'h000C) != 16'h000C);
    endtask

    task automatic set_div(input int d);
        wr(3'd1, 16'(d));
        cur_div = d;
    endtask

    task automatic prep_pattern(input int mode, input logic [7:0] p);
        @(posedge clk);
        smode = mode; pat = p; pidx = '0; pat_pull = 1'b0;
        min_gap = 1000000;
    endtask

    task automatic send_byte(input logic [7:0] tx, input int mode,
                             input logic [7:0] p, input logic [7:0] exp_rx);
        logic [15:0] v;
        prep_pattern(mode, p);
        wr(3'd2, {8'h00, tx});
        wait_idle();
        chk("R8 slot kinds", obs, tx);
        rd(3'd3, v);
        chk("R9 status end of byte", v & 16'h0038, 16'h0038);
        rd(3'd2, v);
        chk("R9 received byte", v, exp_rx);
        rd(3'd3, v);
        chk("R10 rbf cleared by read", v & 16'h0010, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 control after reset", v, 16'h0000);
        rd(3'd3, v); chk("R1 status after reset", v, 16'h000C);
        rd(3'd1, v); chk("R1 divider after reset", v, 99);
        rd(3'd2, v); chk("R1 data after reset", v, 0);

        // R2 divider readback
        set_div(1);
        rd(3'd1, v); chk("R2 divider readback", v, 1);

        // R3/R4 reset without a device
        prep_pattern(0, 8'h00);
        wr(3'd0, 16'h0080);
        rd(3'd0, v); chk("R3 reset bit busy", (v >> 7) & 1, 1);
        wait_idle();
        chk_rng("R3 reset low length", last_len, 479 * 2 + 1, 480 * 2);
        rd(3'd0, v); chk("R4 no presence", v & 16'h00C0, 16'h0000);

        // R4 reset with a device holding the line
        prep_pattern(1, 8'h00);
        wr(3'd0, 16'h0080);
        wait_idle();
        rd(3'd0, v); chk("R4 presence seen", v & 16'h00C0, 16'h0040);

        // R2/R5/R6 slot lengths for divider sweep
        for (int d = 0; d < 4; d++) begin
            set_div(d);
            prep_pattern(0, 8'h00);
            wr(3'd0, 16'h0020);
            rd(3'd0, v); chk("R5 drive-0 bit busy", v & 16'h0030, 16'h0020);
            wait_idle();
            chk_rng("R2 R5 drive-0 low length", last_len, 59 * (d + 1) + 1, 60 * (d + 1));
            wr(3'd0, 16'h0010);
            rd(3'd0, v); chk("R5 write-1 bit busy", v & 16'h0030, 16'h0010);
            wait_idle();
            chk_rng("R2 R5 write-1 low length", last_len, 5 * (d + 1) + 1, 6 * (d + 1));
            rd(3'd0, v); chk("R6 read bit released line", (v >> 3) & 1, 1);
        end

        set_div(1);
        // R6 read bit with device holding the line low
        prep_pattern(1, 8'h00);
        wr(3'd0, 16'h0010);
        wait_idle();
        rd(3'd0, v); chk("R6 read bit low line", (v >> 3) & 1, 0);

        // R7 control write while busy is ignored
        prep_pattern(0, 8'h00);
        base = slot_cnt;
        wr(3'd0, 16'h0020);
        wr(3'd0, 16'h0080);
        wait_idle();
        chk("R7 one action only", slot_cnt - base, 1);
        chk_rng("R7 action was drive-0", last_len, 59 * 2 + 1, 60 * 2);
        rd(3'd0, v); chk("R7 presence untouched", (v >> 6) & 1, 1);

        // R8/R9/R10 byte transfers, line echoes what is written
        send_byte(8'h00, 0, 8'h00, 8'h00);
        chk_rng("R5 recovery gap", min_gap, 9 * 2 + 1, 1000000);
        send_byte(8'hFF, 0, 8'h00, 8'hFF);
        send_byte(8'hA5, 0, 8'h00, 8'hA5);
        send_byte(8'h3C, 0, 8'h00, 8'h3C);
        // Reads: device drives pattern, received = written AND pattern
        send_byte(8'hFF, 2, 8'h5A, 8'h5A);
        send_byte(8'hFF, 2, 8'hC3, 8'hC3);
        send_byte(8'h0F, 2, 8'h33, 8'h03);

        // R7 control write while a byte is in flight
        prep_pattern(0, 8'h00);
        base = slot_cnt;
        wr(3'd2, 16'h0081);
        wr(3'd0, 16'h0080);
        wait_idle();
        chk("R7 control ignored during byte", slot_cnt - base, 8);

        // R11 holding buffer
        prep_pattern(0, 8'h00);
        base = slot_cnt;
        wr(3'd2, 16'h0012);
        rd(3'd3, v); chk("R11 buffer moved to shifter", v & 16'h000C, 16'h0004);
        wr(3'd2, 16'h0034);
        rd(3'd3, v); chk("R11 buffer full", v & 16'h0004, 0);
        wr(3'd2, 16'h0056);
        wait_idle();
        chk("R11 third write ignored", slot_cnt - base, 16);
        rd(3'd2, v); chk("R11 last byte received", v, 16'h0034);

        // R12 interrupt enable storage
        wr(3'd4, 16'hFFFF);
        rd(3'd4, v); chk("R12 enable mask", v, 16'h003C);
        wr(3'd4, 16'h0014);
        rd(3'd4, v); chk("R12 enable value", v, 16'h0014);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule